// File: doc/BRIEF.md
# Folded Matrix-Vector Streaming Unit

This block multiplies a signed weight matrix by a signed activation vector and streams out the result. Activations and weights both arrive on ready/valid/data streams in the AXI4-Stream style. The hardware has `PE` processing elements, one per matrix row in flight, and each has `SIMD` multiplier lanes, one per column in flight. A row therefore takes `MAT_W/SIMD` cycles, called synapse folds. The rows are covered in `MAT_H/PE` passes, called row groups or neuron folds.

The first row group consumes the activation stream. Each activation chunk is written into a small local buffer while it is also used. Every later row group replays the chunks from that buffer, so the activation stream is idle after the first group. After the last fold of each group, one output beat carries the `PE` accumulated sums.

When the output is back-pressured, the unit keeps working until it has finished one more complete row group. It holds that result internally and then deasserts both input readies until the output slot drains.

Top module: `fold_mv_unit`

## Requirements
- R1: During and right after a synchronous active-low reset, `out_valid` is low, and with no input valid neither `wt_ready` nor `act_ready` is high.
- R2: Each output beat holds, for each PE p of row group g, the two's-complement sum over all columns j of weight[g*PE+p][j] times activation[j], truncated to `OUT_W` bits. Beats leave in row-group order, and PE p occupies bits [p*OUT_W +: OUT_W].
- R3: An activation beat is accepted only during the first row group of a vector, and only together with a weight beat. Exactly `MAT_W/SIMD` activation beats are taken per vector, and later row groups reuse the stored copy.
- R4: Activation lane l sits at bits [l*IN_W +: IN_W]. In a weight beat, the weight for PE p and lane l sits at bits [(p*SIMD+l)*WT_W +: WT_W]. Weight beats are ordered by row group first and synapse fold second, and fold s covers columns s*SIMD to s*SIMD+SIMD-1.
- R5: A beat moves on a stream only in a cycle where both its valid and its ready are high. Gaps in either input stream lose no data, and `out_valid` falls only after a cycle where `out_ready` was high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged.
- R7: Under sustained output back pressure, the unit completes exactly one more row group beyond the one waiting on the output. It then holds `wt_ready` and `act_ready` low until the output is taken.
- R8: The lane products are signed, so the most negative operands give correct positive and negative sums.
- R9: With both input streams always valid and `out_ready` always high, a weight beat is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_valid | input | 1 | Activation beat valid |
| act_ready | output | 1 | Activation beat accepted this cycle when valid is high |
| act_data | input | SIMD*IN_W | SIMD signed activation elements |
| wt_valid | input | 1 | Weight beat valid |
| wt_ready | output | 1 | Weight beat accepted this cycle when valid is high |
| wt_data | input | PE*SIMD*WT_W | PE x SIMD signed weights |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream accepts result beat |
| out_data | output | PE*OUT_W | PE signed sums, PE 0 in the low bits |

## Verification
The hardest state to reach is the one where one result waits on the output and a second completed row group waits inside the block, with both inputs frozen. No single port shows this state, and it only appears when back pressure lasts longer than a whole row group.

The bench holds `out_ready` low from the very first beat while both streams offer two whole vectors. It then counts the weight and activation handshakes; the count must stop exactly two row groups in. It also samples the held output twice before releasing it. After the release, the bench checks that both held results come out in order, followed by the rest of the stream under a changing ready pattern.

// File: rtl/mvu_pkg.sv
`timescale 1ns/1ps
package mvu_pkg;
    // Sequencer phase: IDLE = finished group parked waiting for the output slot,
    // READ = first row group (activation stream being captured),
    // WRITE = later row groups (activation replayed from the buffer).
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } mvu_state_e;
endpackage

// File: rtl/mvu_ctrl.sv
`timescale 1ns/1ps
module mvu_ctrl
    import mvu_pkg::*;
#(
    parameter int SF = 2,
    parameter int NF = 2,
    localparam int SF_IW = (SF > 1) ? $clog2(SF) : 1,
    localparam int NF_IW = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_valid_i,
    input  logic             wt_valid_i,
    input  logic             out_free_i,
    output logic             act_ready_o,
    output logic             wt_ready_o,
    output logic             step_o,
    output logic             last_o,
    output logic             hold_o,
    output logic             drain_o,
    output logic             fill_o,
    output logic [SF_IW-1:0] fold_o,
    output mvu_state_e       state_o
);
    typedef struct packed {
        logic [SF_IW-1:0] fold;
        logic [NF_IW-1:0] grp;
        logic             pend;
        mvu_state_e       state;
    } ctrl_t;

    ctrl_t q, d;

    logic fill, last, step;

    always_comb begin
        d    = q;
        fill = (q.grp == '0);
        last = (q.fold == SF_IW'(SF - 1));

        // Activation is only needed while the buffer is being filled.
        act_ready_o = !q.pend && fill && wt_valid_i;
        wt_ready_o  = !q.pend && (!fill || act_valid_i);
        step        = wt_valid_i && wt_ready_o;

        hold_o  = step && last && !out_free_i;
        drain_o = q.pend && out_free_i;

        if (step) begin
            if (last) begin
                d.fold = '0;
                d.grp  = (q.grp == NF_IW'(NF - 1)) ? '0 : q.grp + NF_IW'(1);
            end else begin
                d.fold = q.fold + SF_IW'(1);
            end
        end

        if (hold_o) begin
            d.pend = 1'b1;
        end else if (drain_o) begin
            d.pend = 1'b0;
        end

        if (d.pend) begin
            d.state = ST_IDLE;
        end else if (d.grp == '0) begin
            d.state = ST_READ;
        end else begin
            d.state = ST_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{fold: '0, grp: '0, pend: 1'b0, state: ST_READ};
        end else begin
            q <= d;
        end
    end

    assign step_o  = step;
    assign last_o  = last;
    assign fill_o  = fill;
    assign fold_o  = q.fold;
    assign state_o = q.state;
endmodule

// File: rtl/mvu_act_buf.sv
`timescale 1ns/1ps
module mvu_act_buf #(
    parameter int SF      = 2,
    parameter int CHUNK_W = 16,
    localparam int SF_IW  = (SF > 1) ? $clog2(SF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               fill_i,
    input  logic [SF_IW-1:0]   addr_i,
    input  logic [CHUNK_W-1:0] din_i,
    output logic [CHUNK_W-1:0] dout_o
);
    logic [CHUNK_W-1:0] mem_q [SF];
    logic [CHUNK_W-1:0] mem_d [SF];

    always_comb begin
        for (int i = 0; i < SF; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_i) begin
            mem_d[addr_i] = din_i;
        end
        // First group uses the live stream; later groups replay.
        dout_o = fill_i ? din_i : mem_q[addr_i];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SF; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/mvu_pe.sv
`timescale 1ns/1ps
module mvu_pe #(
    parameter int SIMD  = 4,
    parameter int IN_W  = 4,
    parameter int WT_W  = 4,
    parameter int OUT_W = 16,
    localparam int PW   = IN_W + WT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_i,
    input  logic                 clear_i,
    input  logic                 drain_i,
    input  logic [SIMD*IN_W-1:0] act_i,
    input  logic [SIMD*WT_W-1:0] wt_i,
    output logic [OUT_W-1:0]     sum_o,
    output logic [OUT_W-1:0]     acc_o
);
    typedef struct packed {
        logic [OUT_W-1:0] acc;
    } pe_t;

    pe_t q, d;

    logic signed [PW-1:0] prod [SIMD];
    logic [OUT_W-1:0]     dot;

    for (genvar l = 0; l < SIMD; l++) begin : g_lane
        assign prod[l] = $signed(act_i[l*IN_W +: IN_W]) * $signed(wt_i[l*WT_W +: WT_W]);
    end

    always_comb begin
        dot = '0;
        for (int l = 0; l < SIMD; l++) begin
            dot = dot + {{(OUT_W-PW){prod[l][PW-1]}}, prod[l]};
        end
        sum_o = q.acc + dot;

        d = q;
        if (step_i) begin
            d.acc = clear_i ? '0 : sum_o;
        end else if (drain_i) begin
            d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc_o = q.acc;
endmodule

// File: rtl/fold_mv_unit.sv
`timescale 1ns/1ps
module fold_mv_unit
    import mvu_pkg::*;
#(
    parameter int MAT_W = 8,
    parameter int MAT_H = 4,
    parameter int PE    = 2,
    parameter int SIMD  = 4,
    parameter int IN_W  = 4,
    parameter int WT_W  = 4,
    parameter int OUT_W = 16,
    localparam int SF      = MAT_W / SIMD,
    localparam int NF      = MAT_H / PE,
    localparam int SF_IW   = (SF > 1) ? $clog2(SF) : 1,
    localparam int CHUNK_W = SIMD * IN_W,
    localparam int ROW_W   = SIMD * WT_W,
    localparam int WBEAT_W = PE * ROW_W,
    localparam int OBEAT_W = PE * OUT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_valid,
    output logic               act_ready,
    input  logic [CHUNK_W-1:0] act_data,
    input  logic               wt_valid,
    output logic               wt_ready,
    input  logic [WBEAT_W-1:0] wt_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [OBEAT_W-1:0] out_data
);
    typedef struct packed {
        logic               valid;
        logic [OBEAT_W-1:0] data;
    } obuf_t;

    obuf_t q, d;

    logic             out_free, step, last, hold, drain, fill, load_new;
    logic [SF_IW-1:0] fold;
    mvu_state_e       ctrl_state;
    logic [CHUNK_W-1:0] chunk;
    logic [OBEAT_W-1:0] sums, accs;

    assign out_free = !q.valid || out_ready;
    assign load_new = step && last && !hold;

    mvu_ctrl #(.SF(SF), .NF(NF)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_valid_i (act_valid),
        .wt_valid_i  (wt_valid),
        .out_free_i  (out_free),
        .act_ready_o (act_ready),
        .wt_ready_o  (wt_ready),
        .step_o      (step),
        .last_o      (last),
        .hold_o      (hold),
        .drain_o     (drain),
        .fill_o      (fill),
        .fold_o      (fold),
        .state_o     (ctrl_state)
    );

    mvu_act_buf #(.SF(SF), .CHUNK_W(CHUNK_W)) i_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (step && fill),
        .fill_i (fill),
        .addr_i (fold),
        .din_i  (act_data),
        .dout_o (chunk)
    );

    for (genvar p = 0; p < PE; p++) begin : g_pe
        mvu_pe #(.SIMD(SIMD), .IN_W(IN_W), .WT_W(WT_W), .OUT_W(OUT_W)) i_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_i  (step),
            .clear_i (load_new),
            .drain_i (drain),
            .act_i   (chunk),
            .wt_i    (wt_data[p*ROW_W +: ROW_W]),
            .sum_o   (sums[p*OUT_W +: OUT_W]),
            .acc_o   (accs[p*OUT_W +: OUT_W])
        );
    end

    always_comb begin
        d = q;
        if (q.valid && out_ready) begin
            d.valid = 1'b0;
        end
        if (load_new) begin
            d.valid = 1'b1;
            d.data  = sums;
        end else if (drain) begin
            d.valid = 1'b1;
            d.data  = accs;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.valid;
    assign out_data  = q.data;
endmodule

// File: rtl/mvu_chk.sv
`timescale 1ns/1ps
module mvu_chk
    import mvu_pkg::*;
#(
    parameter int OBEAT_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               act_valid,
    input logic               act_ready,
    input logic               wt_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [OBEAT_W-1:0] out_data,
    input mvu_state_e         ctrl_state
);
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5
    out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_ready));

    // R3
    act_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_ready) |-> wt_ready);

    // R7
    park_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_IDLE) |-> (!wt_ready && !act_ready));

    // R7
    park_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_IDLE) |-> out_valid);
endmodule

bind fold_mv_unit mvu_chk #(.OBEAT_W(OBEAT_W)) i_mvu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_valid  (act_valid),
    .act_ready  (act_ready),
    .wt_ready   (wt_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .ctrl_state (ctrl_state)
);

// File: tb/test_fold_mv_unit.sv
`timescale 1ns/1ps
module test_fold_mv_unit;
    localparam int MAT_W = 8, MAT_H = 4, PE = 2, SIMD = 4;
    localparam int IN_W = 4, WT_W = 4, OUT_W = 16;
    localparam int SF = MAT_W / SIMD, NF = MAT_H / PE;
    localparam int CHUNK_W = SIMD * IN_W, WBEAT_W = PE * SIMD * WT_W, OBEAT_W = PE * OUT_W;
    localparam int NV = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic act_valid = 1'b0, wt_valid = 1'b0, out_ready = 1'b0;
    logic act_ready, wt_ready, out_valid;
    logic [CHUNK_W-1:0] act_data = '0;
    logic [WBEAT_W-1:0] wt_data = '0;
    logic [OBEAT_W-1:0] out_data;

    always #2 clk = ~clk;

    fold_mv_unit #(.MAT_W(MAT_W), .MAT_H(MAT_H), .PE(PE), .SIMD(SIMD),
                   .IN_W(IN_W), .WT_W(WT_W), .OUT_W(OUT_W)) i_fold_mv_unit (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_ready(act_ready), .act_data(act_data),
        .wt_valid(wt_valid), .wt_ready(wt_ready), .wt_data(wt_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int checks = 0, errors = 0;
    int wm [NV][MAT_H][MAT_W];
    int am [NV][MAT_W];
    logic [OBEAT_W-1:0] exp_q [$];
    int                 vec_q [$];
    int act_cnt = 0, wt_cnt = 0, rx_cnt = 0, wt_vec_done = 0;
    int wt_wait [NV];
    int rmode = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, actv, expv);
        end
    endtask

    // Scoreboard feed: expected beats of vector v, per R2 / R4.
    task automatic push_expected(input int v);
        for (int g = 0; g < NF; g++) begin
            logic [OBEAT_W-1:0] e;
            e = '0;
            for (int p = 0; p < PE; p++) begin
                int s;
                logic [31:0] t;
                s = 0;
                for (int j = 0; j < MAT_W; j++) s += wm[v][g*PE+p][j] * am[v][j];
                t = s;
                e[p*OUT_W +: OUT_W] = t[OUT_W-1:0];
            end
            exp_q.push_back(e);
            vec_q.push_back(v);
        end
    endtask

    function automatic int gap_of(input int v, input int k);
        return (v < 6) ? 0 : ((v + k) % 3);
    endfunction

    task automatic act_driver();
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < SF; s++) begin
                logic [CHUNK_W-1:0] c;
                for (int l = 0; l < SIMD; l++) begin
                    logic [31:0] t;
                    t = am[v][s*SIMD+l];
                    c[l*IN_W +: IN_W] = t[IN_W-1:0];
                end
                repeat (gap_of(v, s + 1)) @(negedge clk);
                act_data  = c;
                act_valid = 1'b1;
                forever begin
                    #1;
                    if (act_ready) break;
                    @(negedge clk);
                end
                @(negedge clk);
                act_valid = 1'b0;
                act_cnt++;
            end
        end
    endtask

    task automatic wt_driver();
        for (int v = 0; v < NV; v++) begin
            wt_wait[v] = 0;
            push_expected(v);
            for (int g = 0; g < NF; g++) begin
                for (int s = 0; s < SF; s++) begin
                    logic [WBEAT_W-1:0] b;
                    for (int p = 0; p < PE; p++) begin
                        for (int l = 0; l < SIMD; l++) begin
                            logic [31:0] t;
                            t = wm[v][g*PE+p][s*SIMD+l];
                            b[(p*SIMD+l)*WT_W +: WT_W] = t[WT_W-1:0];
                        end
                    end
                    repeat (gap_of(v, g + s)) @(negedge clk);
                    wt_data  = b;
                    wt_valid = 1'b1;
                    forever begin
                        #1;
                        if (wt_ready) break;
                        wt_wait[v]++;
                        @(negedge clk);
                    end
                    @(negedge clk);
                    wt_valid = 1'b0;
                    wt_cnt++;
                end
            end
            wt_vec_done = v + 1;
        end
    endtask

    // Monitor: sets out_ready per mode, compares each accepted beat.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (rmode)
                0: out_ready = 1'b0;
                1: out_ready = 1'b1;
                default: out_ready = ((cyc % 4) != 0) && ((cyc % 23) > 4);
            endcase
            if (rst_n && out_valid && out_ready) begin
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected output beat", out_data, 0);
                end else begin
                    logic [OBEAT_W-1:0] e;
                    int v;
                    e = exp_q.pop_front();
                    v = vec_q.pop_front();
                    if (v == 6 || v == 7)
                        chk(out_data == e, "R8", "signed extreme beat", out_data, e);
                    else
                        chk(out_data == e, "R2/R4", "result beat", out_data, e);
                end
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", rx_cnt, NV*NF);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [OBEAT_W-1:0] held;
        for (int v = 0; v < NV; v++) begin
            for (int r = 0; r < MAT_H; r++) begin
                for (int j = 0; j < MAT_W; j++) begin
                    if (v == 6)      wm[v][r][j] = -8;
                    else if (v == 7) wm[v][r][j] = 7;
                    else             wm[v][r][j] = int'($urandom_range(15)) - 8;
                end
            end
            for (int j = 0; j < MAT_W; j++) begin
                am[v][j] = (v == 6 || v == 7) ? -8 : int'($urandom_range(15)) - 8;
            end
        end

        repeat (4) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(wt_ready == 1'b0 && act_ready == 1'b0, "R1", "readies idle", {wt_ready, act_ready}, 0);
        @(negedge clk);

        // Back pressure from the first beat.
        fork
            act_driver();
            wt_driver();
        join_none
        repeat (40) @(negedge clk);
        #1;
        chk(wt_cnt == 2*SF, "R7", "weight beats taken under stall", wt_cnt, 2*SF);
        chk(act_cnt == SF, "R3", "activation beats taken under stall", act_cnt, SF);
        chk(wt_ready == 1'b0 && act_ready == 1'b0, "R7", "inputs blocked", {wt_ready, act_ready}, 0);
        chk(out_valid == 1'b1, "R6", "output held valid", out_valid, 1);
        held = out_data;
        repeat (5) @(negedge clk);
        #1;
        chk(out_data == held, "R6", "output stable under stall", out_data, held);
        chk(rx_cnt == 0, "R5", "no beat without ready", rx_cnt, 0);

        rmode = 1;
        wait (wt_vec_done >= 6);
        rmode = 2;
        for (int v = 3; v < 6; v++) begin
            chk(wt_wait[v] == 0, "R9", "weight waits at full rate", wt_wait[v], 0);
        end

        wait (rx_cnt == NV*NF);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        chk(act_cnt == NV*SF, "R3", "total activation beats", act_cnt, NV*SF);
        chk(wt_cnt == NV*NF*SF, "R5", "total weight beats", wt_cnt, NV*NF*SF);
        chk(rx_cnt == NV*NF, "R5", "total output beats", rx_cnt, NV*NF);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule